// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block sends four 24-bit audio samples, arranged as two stereo pairs, out of a chip as a serial bus master. From a single clock enable it builds the bit clock and the frame clock itself. The data leaves either on two data lines, one stereo pair each, or on a single line that carries all four channels in time slots. A 3-bit format field picks the framing:

- I2S
- left-justified
- right-justified
- a DSP-style short-sync format
- two packed TDM layouts of 128 and 256 bit clocks per frame

A 2-bit field picks the word length.

The surrounding logic places a new set of samples on `smp_i` and pulses `smp_load`. The block keeps that set in a holding register. It switches to the held set, the format field and the width field only when a new frame starts. A frame that has already begun is therefore never corrupted by a late write. `BCLK` flips on every `bit_en` pulse. Two pulses make one bit period. Data and frame clock change only on the falling edge of `BCLK`, so a receiver can sample on the rising edge.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset `bclk_o`, `lrclk_o` and `sdata_o` are low, and the active setup is I2S at 24 bits. The first frame starts at the first falling edge of `bclk_o`, with bit index 0.
- R2: `bclk_o` inverts in the clock cycle after each cycle in which `bit_en` is high. While `bit_en` is low, `bclk_o`, `lrclk_o` and `sdata_o` hold their values.
- R3: `lrclk_o` and `sdata_o` change only in the cycle where `bclk_o` falls.
- R4: Format code 000 (I2S) uses 64 BCLKs per frame, split into two halves of 32.
  - `lrclk_o` is low in the first half (left) and high in the second (right).
  - Line 0 carries pair 0 and line 1 carries pair 1.
  - The MSB is on the second BCLK of each half.
- R5: Format code 011 (left-justified) uses the same 64-BCLK frame as R4, with `lrclk_o` high in the left half and low in the right half. The MSB is on the first BCLK of each half.
- R6: Format code 001 (right-justified) uses the same frame and `lrclk_o` polarity as R5. A word of W bits starts at BCLK 32-W of its half, so its LSB is on the 32nd BCLK.
- R7: Format code 010 (DSP) uses the same 64-BCLK frame. Left goes first and the MSB is on the second BCLK of each half.
  - `lrclk_o` is high only during the first BCLK of each 32-BCLK half.
  - It therefore pulses at twice the frame rate and does not identify the channel.
- R8: Format code 101 (packed 128) uses 128 BCLKs per frame, split into four 32-BCLK slots on line 0.
  - The slots carry L0, L1, R0, R1 in that order, each MSB first at the start of its slot.
  - `lrclk_o` is high for the first 64 BCLKs.
  - Line 1 stays low in both packed formats.
- R9: Format code 100 (packed 256) uses 256 BCLKs per frame in eight 32-BCLK slots. Slots 1 to 4 carry L0, L1, R0, R1 as in R8 and slots 5 to 8 are all zero. `lrclk_o` is high for the first 128 BCLKs.
- R10: The width code 00, 01, 10 or 11 sends the top 24, 20, 16 or 24 bits of each 24-bit sample. Every other bit position of a half or slot is zero.
- R11: The format and width fields are taken only when a frame starts, so a change in mid-frame shows from the next frame on. Format codes 110 and 111 behave as I2S.
- R12: `smp_load` copies `smp_i` into a holding register. Bits [23:0] are L0, [47:24] are R0, [71:48] are L1 and [95:72] are R1. Each frame sends the set that was held when it started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Half-bit clock enable; each pulse flips BCLK |
| mode_i | input | 3 | Frame format code |
| width_i | input | 2 | Word length code |
| smp_load | input | 1 | Strobe that captures `smp_i` |
| smp_i | input | 96 | Four samples: L0, R0, L1, R1 from the low bits up |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame / channel clock |
| sdata_o | output | 2 | Serial data, line 0 and line 1 |

## Verification
A bit with index i appears on `lrclk_o` and `sdata_o` at the clock edge where `bclk_o` falls into that bit. The bench samples each bit 1 ns after the following rising edge of `bclk_o`, so every sample lands half a bit period after the change.

After reset, the first rising edge of `bclk_o` still shows reset values, and bit 0 is read at the second rising edge. The bench counts rising edges from there, so every captured bit is matched to its frame index.

A change of format, width or samples in mid-frame is expected only from index 0 of the next frame. The bench therefore compares the rest of the current frame against the old setup and the following frame against the new one.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;
  localparam logic [2:0] FMT_I2S  = 3'b000;
  localparam logic [2:0] FMT_RJ   = 3'b001;
  localparam logic [2:0] FMT_DSP  = 3'b010;
  localparam logic [2:0] FMT_LJ   = 3'b011;
  localparam logic [2:0] FMT_P256 = 3'b100;
  localparam logic [2:0] FMT_P128 = 3'b101;

  // unused codes fall back to I2S
  function automatic logic [2:0] fmt_norm(input logic [2:0] m);
    return (m[2] & m[1]) ? FMT_I2S : m;
  endfunction

  function automatic logic [5:0] word_bits(input logic [1:0] w);
    case (w)
      2'b01:   return 6'd20;
      2'b10:   return 6'd16;
      default: return 6'd24;
    endcase
  endfunction
endpackage

// File: rtl/atx_bitclk.sv
`timescale 1ns/1ps
module atx_bitclk #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [IDX_W-1:0] last,
  output logic             bclk,
  output logic             fall,
  output logic             wrap,
  output logic [IDX_W-1:0] idx_nxt
);
  logic             bclk_q, bclk_n;
  logic [IDX_W-1:0] idx_q, idx_n;

  assign fall    = bit_en & bclk_q;
  assign wrap    = (idx_q >= last);
  assign idx_nxt = wrap ? '0 : idx_q + 1'b1;
  assign bclk    = bclk_q;

  always_comb begin
    bclk_n = bit_en ? ~bclk_q : bclk_q;
    idx_n  = fall ? idx_nxt : idx_q;
  end

  // index starts at all-ones so the first falling edge opens frame 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      idx_q  <= '1;
    end else begin
      bclk_q <= bclk_n;
      idx_q  <= idx_n;
    end
  end
endmodule

// File: rtl/atx_bitmap.sv
`timescale 1ns/1ps
module atx_bitmap
  import aud_tx_pkg::*;
#(
  parameter int SW    = 24,
  parameter int NPAIR = 2,
  parameter int SLOT  = 32,
  parameter int IDX_W = 8
) (
  input  logic [2:0]            fmt,
  input  logic [5:0]            wbits,
  input  logic [IDX_W-1:0]      idx,
  input  logic [2*NPAIR*SW-1:0] smp,
  output logic                  lr,
  output logic [NPAIR-1:0]      sd
);
  localparam int SLOT_W = $clog2(SLOT);
  localparam int SW_W   = $clog2(SW);
  localparam int NCH    = 2 * NPAIR;
  localparam int SEL_W  = IDX_W - SLOT_W;

  logic [SLOT_W-1:0] pos;
  logic              half;
  logic [SEL_W-1:0]  slot;
  logic              pk;
  logic [SLOT_W:0]   st, wb_s, k;
  logic              win;
  logic [SW_W-1:0]   bsel;
  logic [SW-1:0]     pk_word;

  assign pos  = idx[SLOT_W-1:0];
  assign half = idx[SLOT_W];
  assign slot = idx[IDX_W-1:SLOT_W];
  assign pk   = fmt[2];
  assign wb_s = (SLOT_W+1)'(wbits);

  always_comb begin
    case (fmt)
      FMT_I2S, FMT_DSP: st = (SLOT_W+1)'(1);
      FMT_RJ:           st = (SLOT_W+1)'(SLOT) - wb_s;
      default:          st = '0;
    endcase
    win = ({1'b0, pos} >= st) && ({1'b0, pos} < st + wb_s);
    if (pk) win = win && (slot < SEL_W'(NCH));
    k    = {1'b0, pos} - st;
    bsel = SW_W'(SW - 1) - SW_W'(k);
  end

  always_comb begin
    case (fmt)
      FMT_I2S:        lr = half;
      FMT_RJ, FMT_LJ: lr = ~half;
      FMT_DSP:        lr = (pos == '0);
      FMT_P256:       lr = ~idx[IDX_W-1];
      FMT_P128:       lr = ~idx[IDX_W-2];
      default:        lr = 1'b0;
    endcase
  end

  // slot order: all lefts, then all rights
  always_comb begin
    pk_word = '0;
    for (int s = 0; s < NCH; s++) begin
      if (slot == SEL_W'(s))
        pk_word = smp[((s < NPAIR) ? 2*s : 2*(s-NPAIR)+1)*SW +: SW];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_line
    logic [SW-1:0] nw;
    assign nw = half ? smp[(2*p+1)*SW +: SW] : smp[2*p*SW +: SW];
    if (p == 0) begin : g_first
      assign sd[p] = win & (pk ? pk_word[bsel] : nw[bsel]);
    end else begin : g_other
      assign sd[p] = win & ~pk & nw[bsel];
    end
  end
endmodule

// File: rtl/aud_ser_tx.sv
`timescale 1ns/1ps
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int SW    = 24,
  parameter int NPAIR = 2,
  parameter int SLOT  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic [2:0]            mode_i,
  input  logic [1:0]            width_i,
  input  logic                  smp_load,
  input  logic [2*NPAIR*SW-1:0] smp_i,
  output logic                  bclk_o,
  output logic                  lrclk_o,
  output logic [NPAIR-1:0]      sdata_o
);
  localparam int IDX_W = $clog2(8 * SLOT);
  localparam int SMP_W = 2 * NPAIR * SW;

  logic             fall_w, wrap_w, frm_start;
  logic [IDX_W-1:0] idx_nxt_w, last;
  logic [2:0]       fmt_q, fmt_n;
  logic [5:0]       wb_q, wb_n;
  logic [SMP_W-1:0] pend_q, pend_n, act_q, act_n;
  logic             lr_q, lr_n, lr_b;
  logic [NPAIR-1:0] sd_q, sd_n, sd_b;

  always_comb begin
    case (fmt_q)
      FMT_P256: last = IDX_W'(8*SLOT - 1);
      FMT_P128: last = IDX_W'(4*SLOT - 1);
      default:  last = IDX_W'(2*SLOT - 1);
    endcase
  end

  atx_bitclk #(.IDX_W(IDX_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .last    (last),
    .bclk    (bclk_o),
    .fall    (fall_w),
    .wrap    (wrap_w),
    .idx_nxt (idx_nxt_w)
  );

  assign frm_start = fall_w & wrap_w;

  always_comb begin
    fmt_n  = frm_start ? fmt_norm(mode_i)   : fmt_q;
    wb_n   = frm_start ? word_bits(width_i) : wb_q;
    act_n  = frm_start ? pend_q             : act_q;
    pend_n = smp_load  ? smp_i              : pend_q;
    lr_n   = fall_w    ? lr_b               : lr_q;
    sd_n   = fall_w    ? sd_b               : sd_q;
  end

  atx_bitmap #(.SW(SW), .NPAIR(NPAIR), .SLOT(SLOT), .IDX_W(IDX_W)) u_map (
    .fmt   (fmt_n),
    .wbits (wb_n),
    .idx   (idx_nxt_w),
    .smp   (act_n),
    .lr    (lr_b),
    .sd    (sd_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= FMT_I2S;
      wb_q   <= 6'd24;
      pend_q <= '0;
      act_q  <= '0;
      lr_q   <= 1'b0;
      sd_q   <= '0;
    end else begin
      fmt_q  <= fmt_n;
      wb_q   <= wb_n;
      pend_q <= pend_n;
      act_q  <= act_n;
      lr_q   <= lr_n;
      sd_q   <= sd_n;
    end
  end

  assign lrclk_o = lr_q;
  assign sdata_o = sd_q;
endmodule

// File: rtl/aud_ser_tx_chk.sv
`timescale 1ns/1ps
module aud_ser_tx_chk #(
  parameter int NPAIR = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             bclk_o,
  input logic             lrclk_o,
  input logic [NPAIR-1:0] sdata_o,
  input logic [2:0]       fmt_q,
  input logic             frame_edge
);
  a_r2_bclk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(bclk_o));

  a_r2_bclk_flip: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (bclk_o != $past(bclk_o)));

  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $fell(bclk_o));

  a_r3_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk_o) |-> $fell(bclk_o));

  a_r8_packed_line1_low: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_q[2] |-> (sdata_o[NPAIR-1:1] == '0));

  a_r11_cfg_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_q) |-> ($past(frame_edge) && $fell(bclk_o)));
endmodule

bind aud_ser_tx aud_ser_tx_chk #(.NPAIR(NPAIR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .bclk_o     (bclk_o),
  .lrclk_o    (lrclk_o),
  .sdata_o    (sdata_o),
  .fmt_q      (fmt_q),
  .frame_edge (frm_start)
);

// File: tb/test_aud_ser_tx.sv
`timescale 1ns/1ps
module test_aud_ser_tx;
  logic        clk = 1'b0;
  logic        rst_n, bit_en, smp_load;
  logic [2:0]  mode_i;
  logic [1:0]  width_i;
  logic [95:0] smp_i;
  logic        bclk, lrclk;
  logic [1:0]  sdata;

  int n_chk  = 0;
  int n_fail = 0;
  logic cap_lr [256];
  logic cap_d0 [256];
  logic cap_d1 [256];

  always #4 clk = ~clk;

  aud_ser_tx i_aud_ser_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode_i(mode_i),
    .width_i(width_i), .smp_load(smp_load), .smp_i(smp_i),
    .bclk_o(bclk), .lrclk_o(lrclk), .sdata_o(sdata)
  );

  // {mode, width}
  localparam logic [4:0] VEC [13] = '{
    5'b000_00, 5'b000_10, 5'b001_00, 5'b001_01, 5'b001_10,
    5'b010_00, 5'b011_01, 5'b011_00, 5'b100_00, 5'b101_10,
    5'b101_01, 5'b000_11, 5'b110_00 };

  function automatic logic [2:0] nmode(input logic [2:0] m);
    return (m == 3'b110 || m == 3'b111) ? 3'b000 : m;
  endfunction

  function automatic int wlen(input logic [1:0] w);
    return (w == 2'b01) ? 20 : (w == 2'b10) ? 16 : 24;
  endfunction

  function automatic int flen(input logic [2:0] m);
    return (m == 3'b100) ? 256 : (m == 3'b101) ? 128 : 64;
  endfunction

  function automatic string rtag(input logic [2:0] m);
    case (m)
      3'b000:  return "R4";
      3'b001:  return "R6";
      3'b010:  return "R7";
      3'b011:  return "R5";
      3'b100:  return "R9";
      3'b101:  return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [95:0] mk_smp(input int v);
    logic [95:0] r;
    for (int c = 0; c < 4; c++)
      r[c*24 +: 24] = 24'hC35A96 ^ 24'(c * 32'h3C0F17 + v * 32'h011223);
    return r;
  endfunction

  task automatic chk1(input string tag, input string what, input logic a, input logic e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s actual %b expected %b", tag, what, a, e);
    end
  endtask

  task automatic capture(input int from, input int to);
    for (int i = from; i < to; i++) begin
      @(posedge bclk); #1;
      cap_lr[i] = lrclk; cap_d0[i] = sdata[0]; cap_d1[i] = sdata[1];
    end
  endtask

  task automatic check_frame(input logic [2:0] mode, input logic [1:0] width,
                             input logic [95:0] smp, input string tag);
    logic [2:0] m; int w, len, st, bad_l, bad_0, bad_1, fi_l, fi_0, fi_1;
    logic el, e0, e1;
    logic [23:0] wd0, wd1;
    m = nmode(mode); w = wlen(width); len = flen(m);
    bad_l = 0; bad_0 = 0; bad_1 = 0; fi_l = -1; fi_0 = -1; fi_1 = -1;
    for (int i = 0; i < len; i++) begin
      int s, p, ch;
      s = i / 32; p = i % 32;
      if (m[2]) begin
        ch = (s == 0) ? 0 : (s == 1) ? 2 : (s == 2) ? 1 : (s == 3) ? 3 : -1;
        wd0 = (ch >= 0) ? smp[ch*24 +: 24] : 24'h0;
        e0 = (ch >= 0 && p < w) ? wd0[23-p] : 1'b0;
        e1 = 1'b0;
        el = (i < len/2);
      end else begin
        st = (m == 3'b001) ? 32 - w : (m == 3'b011) ? 0 : 1;
        wd0 = smp[s*24 +: 24];
        wd1 = smp[(2+s)*24 +: 24];
        e0 = (p >= st && p < st + w) ? wd0[23-(p-st)] : 1'b0;
        e1 = (p >= st && p < st + w) ? wd1[23-(p-st)] : 1'b0;
        el = (m == 3'b000) ? (s == 1) : (m == 3'b010) ? (p == 0) : (s == 0);
      end
      if (cap_lr[i] !== el) begin bad_l++; if (fi_l < 0) fi_l = i; end
      if (cap_d0[i] !== e0) begin bad_0++; if (fi_0 < 0) fi_0 = i; end
      if (cap_d1[i] !== e1) begin bad_1++; if (fi_1 < 0) fi_1 = i; end
    end
    n_chk += 3;
    if (bad_l != 0) begin n_fail++;
      $display("FAIL %s R10 lrclk bit %0d actual %b expected %b (%0d bad)", tag, fi_l, cap_lr[fi_l], ~cap_lr[fi_l], bad_l); end
    if (bad_0 != 0) begin n_fail++;
      $display("FAIL %s R10 line0 bit %0d actual %b expected %b (%0d bad)", tag, fi_0, cap_d0[fi_0], ~cap_d0[fi_0], bad_0); end
    if (bad_1 != 0) begin n_fail++;
      $display("FAIL %s R10 line1 bit %0d actual %b expected %b (%0d bad)", tag, fi_1, cap_d1[fi_1], ~cap_d1[fi_1], bad_1); end
  endtask

  // reset, load one sample set, start the bit clock and skip the first rise
  task automatic start_run(input logic [2:0] mode, input logic [1:0] width,
                           input logic [95:0] smp, input bit chk_rst);
    bit_en = 1'b0; smp_load = 1'b0; rst_n = 1'b0;
    mode_i = mode; width_i = width; smp_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    if (chk_rst) begin
      chk1("R1", "bclk after reset", bclk, 1'b0);
      chk1("R1", "lrclk after reset", lrclk, 1'b0);
      chk1("R1", "line0 after reset", sdata[0], 1'b0);
      chk1("R2", "line1 held with bit_en low", sdata[1], 1'b0);
    end
    smp_i = smp; smp_load = 1'b1;
    @(negedge clk); smp_load = 1'b0; bit_en = 1'b1;
    @(posedge bclk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [95:0] s1, s2;
    logic        hb, hl;
    logic [1:0]  hd;

    // vector table
    for (int v = 0; v < 13; v++) begin
      logic [2:0] m; logic [1:0] w;
      m = VEC[v][4:2]; w = VEC[v][1:0];
      start_run(m, w, mk_smp(v), v == 0);
      capture(0, flen(nmode(m)));
      check_frame(m, w, mk_smp(v), rtag(m));
    end

    // directed: hold, mid-frame setup change, mid-frame sample load
    s1 = mk_smp(20); s2 = mk_smp(21);
    start_run(3'b000, 2'b00, s1, 1'b0);
    capture(0, 10);
    bit_en = 1'b0; hb = bclk; hl = lrclk; hd = sdata;
    repeat (4) @(negedge clk);
    chk1("R2", "bclk hold", bclk, hb);
    chk1("R2", "lrclk hold", lrclk, hl);
    chk1("R2", "line0 hold", sdata[0], hd[0]);
    bit_en = 1'b1;
    capture(10, 20);
    mode_i = 3'b011; width_i = 2'b10;
    capture(20, 64);
    check_frame(3'b000, 2'b00, s1, "R11 old frame");
    capture(0, 10);
    smp_i = s2;
    @(negedge clk); smp_load = 1'b1;
    @(negedge clk); smp_load = 1'b0;
    capture(10, 64);
    check_frame(3'b011, 2'b10, s1, "R12 R11 new setup old samples");
    capture(0, 64);
    check_frame(3'b011, 2'b10, s2, "R12 new samples");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule